// File: doc/BRIEF.md
# Clocked Serial Master Shift Engine

This block runs one side of a synchronous serial link as clock master. Software or a FIFO loads a frame of 5 to 9 bits through a write port. The engine then toggles the serial clock on each tick from an external rate divider. It sends the frame least significant bit first on the data line and captures the incoming line into a receive register. When the frame is complete, a receive-full flag is raised, and it can raise a receive interrupt request. The engine reports an overrun if the previous frame was not collected in time.

When a second frame is written while one is still being sent, the two frames run back to back. A two-bit wait code holds the clock high for a chosen number of extra bit times between them, from zero to three. A separate control input pins the data line high without stopping clocks or reception.

Top module: `sershift_master`

## Requirements
- R1: After reset, `serClk` and `serOut` are 1, and `rxFull`, `rxOverrun` and `rxIrq` are 0.
- R2: A `txWrite` while `txEnable` is 1 stores `txData` and starts a frame. A `txWrite` while `txEnable` is 0 is dropped: no clock edge follows, and the data is not sent later.
- R3: `lenSel` sets the frame length to `lenSel`+5 for codes 0 to 4. Codes 5 to 7 give 9 bits. The length is taken when the frame starts.
- R4: Each half bit lasts one `sckTick`. `serClk` falls, then rises. Bit 0 goes out first. `serOut` holds a bit from the falling edge through the next rising edge, and `serIn` is sampled at each rising edge.
- R5: At the last rising edge of a frame, the received bits are loaded into `rxData` (bit n taken at the n-th rising edge, bits above the length read 0), and `rxFull` is set.
- R6: `rxRead` clears `rxFull` and `rxOverrun` unless a frame completes in the same cycle.
- R7: `rxIrq` is 1 exactly while `rxFull` and `rxIntEn` are both 1.
- R8: When a frame completes while `rxFull` is 1 and no `rxRead` is given, `rxOverrun` is set and `rxData` takes the new frame.
- R9: When `rxRead` coincides with frame completion, the new data is stored, `rxFull` stays 1 and `rxOverrun` ends at 0.
- R10: When a write is pending as a frame ends, `serClk` stays high for 2·`waitSel`+1 ticks before the next falling edge (one tick for code 0). A frame started from idle has no added pause.
- R11: While `forceHigh` is 1, `serOut` is 1 and reception continues.
- R12: Between frames, `serOut` and `serClk` return to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sckTick | input | 1 | One-cycle half-bit enable from the rate divider |
| txEnable | input | 1 | Allows transmit writes |
| txWrite | input | 1 | Transmit register write strobe |
| txData | input | 9 | Transmit data |
| lenSel | input | 3 | Frame length code |
| waitSel | input | 2 | Pause code between chained frames |
| forceHigh | input | 1 | Pins `serOut` high |
| rxIntEn | input | 1 | Receive interrupt enable |
| rxRead | input | 1 | Receive register read strobe |
| serIn | input | 1 | Serial data in |
| serClk | output | 1 | Serial clock, idles high |
| serOut | output | 1 | Serial data out |
| rxData | output | 9 | Received data |
| rxFull | output | 1 | Receive register holds unread data |
| rxOverrun | output | 1 | A frame replaced unread data |
| rxIrq | output | 1 | Receive interrupt request |

## Verification
Two functions can land on the same clock edge: frame completion, which loads the receive register, and a receive-register read. The bench first leaves one frame unread. It then starts another and, using its own knowledge of the tick phase, raises `rxRead` in exactly the cycle whose tick produces the final rising edge. The result is judged by requiring that `rxFull` stays 1, `rxOverrun` stays 0 and `rxData` holds the new frame.

// File: rtl/sershift_pkg.sv
package sershift_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_GAP  = 2'd2
  } engState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;    // move transmit register into shifter, clear capture
    logic fall;    // drive serial clock low
    logic rise;    // drive serial clock high, sample input, advance shifter
    logic done;    // last rising edge of the frame
    logic active;  // frame in progress, data line follows shifter
  } engStrobe_t;

endpackage

// File: rtl/sershift_ctrl.sv
module sershift_ctrl
  import sershift_pkg::*;
#(
  parameter int DATA_W  = 9,
  parameter int MIN_LEN = 5,
  parameter int LEN_W   = 3,
  parameter int WAIT_W  = 2,
  localparam int CNT_W  = $clog2(DATA_W),
  localparam int GAP_W  = WAIT_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sckTick,
  input  logic             txEnable,
  input  logic             txWrite,
  input  logic [LEN_W-1:0] lenSel,
  input  logic [WAIT_W-1:0] waitSel,
  output engStrobe_t       strb,
  output logic [CNT_W-1:0] bitIdx
);

  engState_e        state;
  logic             pending;
  logic             phaseLow;
  logic [CNT_W-1:0] bitCnt;
  logic [CNT_W-1:0] lenLast;
  logic [GAP_W-1:0] gapCnt;

  function automatic logic [CNT_W-1:0] lastIndex(input logic [LEN_W-1:0] code);
    if (int'(code) > DATA_W - MIN_LEN) return CNT_W'(DATA_W - 1);
    return CNT_W'(int'(code) + MIN_LEN - 1);
  endfunction

  assign bitIdx = bitCnt;

  always_comb begin
    strb        = '0;
    strb.active = (state == ST_RUN);
    unique case (state)
      ST_IDLE: strb.load = pending;
      ST_RUN: begin
        if (sckTick) begin
          if (!phaseLow) begin
            strb.fall = 1'b1;
          end else begin
            strb.rise = 1'b1;
            if (bitCnt == lenLast) begin
              strb.done = 1'b1;
              strb.load = pending && (waitSel == '0);
            end
          end
        end
      end
      ST_GAP:  strb.load = sckTick && (gapCnt == GAP_W'(1));
      default: strb.load = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending <= 1'b0;
    end else if (txWrite && txEnable) begin
      pending <= 1'b1;
    end else if (strb.load) begin
      pending <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      phaseLow <= 1'b0;
      bitCnt   <= '0;
      lenLast  <= CNT_W'(DATA_W - 1);
      gapCnt   <= '0;
    end else begin
      if (strb.load) begin
        state    <= ST_RUN;
        phaseLow <= 1'b0;
        bitCnt   <= '0;
        lenLast  <= lastIndex(lenSel);
      end else begin
        unique case (state)
          ST_RUN: begin
            if (strb.fall) begin
              phaseLow <= 1'b1;
            end else if (strb.rise) begin
              phaseLow <= 1'b0;
              if (strb.done) begin
                if (pending) begin
                  state  <= ST_GAP;
                  gapCnt <= {waitSel, 1'b0};
                end else begin
                  state <= ST_IDLE;
                end
              end else begin
                bitCnt <= bitCnt + CNT_W'(1);
              end
            end
          end
          ST_GAP: if (sckTick) gapCnt <= gapCnt - GAP_W'(1);
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  // one clock edge per tick
  p_edge_excl_r4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.fall, strb.rise}));

  // bit index never runs past the latched frame length
  p_len_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN) |-> (bitCnt <= lenLast && lenLast <= CNT_W'(DATA_W - 1)
                           && lenLast >= CNT_W'(MIN_LEN - 1)));

  // a pause always ends in a new frame, never in idle
  p_gap_exit_r10: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_GAP) |=> (state == ST_GAP || state == ST_RUN));

endmodule

// File: rtl/sershift_dpath.sv
module sershift_dpath
  import sershift_pkg::*;
#(
  parameter int DATA_W = 9,
  localparam int CNT_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  engStrobe_t        strb,
  input  logic [CNT_W-1:0]  bitIdx,
  input  logic              txEnable,
  input  logic              txWrite,
  input  logic [DATA_W-1:0] txData,
  input  logic              rxRead,
  input  logic              rxIntEn,
  input  logic              forceHigh,
  input  logic              serIn,
  output logic              serClk,
  output logic              serOut,
  output logic [DATA_W-1:0] rxData,
  output logic              rxFull,
  output logic              rxOverrun,
  output logic              rxIrq
);

  logic [DATA_W-1:0] txReg;
  logic [DATA_W-1:0] txShift;
  logic [DATA_W-1:0] rxShift;
  logic [DATA_W-1:0] rxNext;

  always_comb begin
    rxNext         = rxShift;
    rxNext[bitIdx] = serIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txReg <= '1;
    end else if (txWrite && txEnable) begin
      txReg <= txData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '1;
      rxShift <= '0;
    end else if (strb.load) begin
      txShift <= txReg;
      rxShift <= '0;
    end else if (strb.rise) begin
      txShift <= {1'b1, txShift[DATA_W-1:1]};
      rxShift <= rxNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      serClk <= 1'b1;
    end else if (strb.fall) begin
      serClk <= 1'b0;
    end else if (strb.rise) begin
      serClk <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxData    <= '0;
      rxFull    <= 1'b0;
      rxOverrun <= 1'b0;
    end else if (strb.done) begin
      rxData    <= rxNext;
      rxFull    <= 1'b1;
      rxOverrun <= rxFull && !rxRead;
    end else if (rxRead) begin
      rxFull    <= 1'b0;
      rxOverrun <= 1'b0;
    end
  end

  assign serOut = (forceHigh || !strb.active) ? 1'b1 : txShift[0];
  assign rxIrq  = rxFull && rxIntEn;

  p_full_set_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.done |=> rxFull);

  p_read_clr_r6: assert property (@(posedge clk) disable iff (!rstN)
    (rxRead && !strb.done) |=> (!rxFull && !rxOverrun));

  p_overrun_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.done && rxFull && !rxRead) |=> rxOverrun);

  p_collide_r9: assert property (@(posedge clk) disable iff (!rstN)
    (strb.done && rxRead) |=> (rxFull && !rxOverrun));

  p_clk_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.fall && !strb.rise) |=> $stable(serClk));

  p_irq_follow_r7: assert property (@(posedge clk) disable iff (!rstN)
    (rxIntEn && $rose(rxFull)) |-> rxIrq);

endmodule

// File: rtl/sershift_master.sv
module sershift_master
  import sershift_pkg::*;
#(
  parameter int DATA_W  = 9,
  parameter int MIN_LEN = 5,
  parameter int LEN_W   = 3,
  parameter int WAIT_W  = 2,
  localparam int CNT_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sckTick,
  input  logic              txEnable,
  input  logic              txWrite,
  input  logic [DATA_W-1:0] txData,
  input  logic [LEN_W-1:0]  lenSel,
  input  logic [WAIT_W-1:0] waitSel,
  input  logic              forceHigh,
  input  logic              rxIntEn,
  input  logic              rxRead,
  input  logic              serIn,
  output logic              serClk,
  output logic              serOut,
  output logic [DATA_W-1:0] rxData,
  output logic              rxFull,
  output logic              rxOverrun,
  output logic              rxIrq
);

  engStrobe_t       strb;
  logic [CNT_W-1:0] bitIdx;

  sershift_ctrl #(
    .DATA_W (DATA_W),
    .MIN_LEN(MIN_LEN),
    .LEN_W  (LEN_W),
    .WAIT_W (WAIT_W)
  ) i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .sckTick (sckTick),
    .txEnable(txEnable),
    .txWrite (txWrite),
    .lenSel  (lenSel),
    .waitSel (waitSel),
    .strb    (strb),
    .bitIdx  (bitIdx)
  );

  sershift_dpath #(
    .DATA_W(DATA_W)
  ) i_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .bitIdx   (bitIdx),
    .txEnable (txEnable),
    .txWrite  (txWrite),
    .txData   (txData),
    .rxRead   (rxRead),
    .rxIntEn  (rxIntEn),
    .forceHigh(forceHigh),
    .serIn    (serIn),
    .serClk   (serClk),
    .serOut   (serOut),
    .rxData   (rxData),
    .rxFull   (rxFull),
    .rxOverrun(rxOverrun),
    .rxIrq    (rxIrq)
  );

endmodule

// File: tb/test_sershift_master.sv
`timescale 1ns/1ps
module test_sershift_master;

  localparam int TICK_DIV = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sckTick = 1'b0;
  logic       txEnable = 1'b0;
  logic       txWrite = 1'b0;
  logic [8:0] txData = '0;
  logic [2:0] lenSel = 3'd3;
  logic [1:0] waitSel = 2'd0;
  logic       forceHigh = 1'b0;
  logic       rxIntEn = 1'b0;
  logic       rxRead = 1'b0;
  logic       serIn = 1'b0;
  logic       serClk, serOut, rxFull, rxOverrun, rxIrq;
  logic [8:0] rxData;

  sershift_master i_sershift_master (
    .clk(clk), .rstN(rstN), .sckTick(sckTick), .txEnable(txEnable),
    .txWrite(txWrite), .txData(txData), .lenSel(lenSel), .waitSel(waitSel),
    .forceHigh(forceHigh), .rxIntEn(rxIntEn), .rxRead(rxRead), .serIn(serIn),
    .serClk(serClk), .serOut(serOut), .rxData(rxData), .rxFull(rxFull),
    .rxOverrun(rxOverrun), .rxIrq(rxIrq)
  );

  always #2.5 clk = ~clk;

  typedef struct {
    logic [8:0] tx;
    logic [8:0] rx;
    int         len;
    bit         chained;
    int         waitCode;
    bit         allOnes;
  } frameExp_t;

  frameExp_t expQ[$];
  int checks = 0;
  int fails  = 0;
  int fallCount = 0;
  int bitNum = 0;
  int highCnt = 0;
  logic prevClk = 1'b1;
  logic [8:0] monCap = '0;
  int tickCnt = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int lenOf(input int code);
    return (code > 4) ? 9 : code + 5;
  endfunction

  function automatic logic [8:0] maskOf(input int len);
    return 9'((1 << len) - 1);
  endfunction

  // half-bit tick generator
  always @(negedge clk) begin
    tickCnt = (tickCnt + 1) % TICK_DIV;
    sckTick = (tickCnt == TICK_DIV - 1);
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rstN) begin
      if (!serClk && prevClk) begin
        fallCount++;
        if (expQ.size() == 0) begin
          chk(1'b0, "R2 unexpected clock edge", 0, 1);
        end else begin
          if (bitNum == 0 && expQ[0].chained)
            chk(highCnt == (2 * expQ[0].waitCode + 1) * TICK_DIV,
                "R10 pause between chained frames", highCnt,
                (2 * expQ[0].waitCode + 1) * TICK_DIV);
          else if (bitNum != 0)
            chk(highCnt == TICK_DIV, "R4 half-bit high width", highCnt, TICK_DIV);
          monCap[bitNum] = serOut;
        end
        highCnt = 0;
      end
      if (serClk && !prevClk && expQ.size() != 0) begin
        bitNum++;
        if (bitNum == expQ[0].len) begin
          if (expQ[0].allOnes)
            chk((monCap & maskOf(bitNum)) == maskOf(bitNum), "R11 forced-high data line",
                int'(monCap & maskOf(bitNum)), int'(maskOf(bitNum)));
          else
            chk((monCap & maskOf(bitNum)) == (expQ[0].tx & maskOf(bitNum)),
                "R4 transmitted bits LSB first", int'(monCap & maskOf(bitNum)),
                int'(expQ[0].tx & maskOf(bitNum)));
          void'(expQ.pop_front());
          bitNum = 0;
          monCap = '0;
        end
        serIn = (expQ.size() != 0) ? expQ[0].rx[bitNum] : 1'b0;
      end
      if (serClk) highCnt++;
      else highCnt = 0;
      prevClk = serClk;
    end
  end

  task automatic sendFrame(input logic [8:0] tx, input logic [8:0] rx,
                           input int code, input bit chained);
    frameExp_t e;
    e.tx = tx; e.rx = rx; e.len = lenOf(code); e.chained = chained;
    e.waitCode = int'(waitSel); e.allOnes = forceHigh;
    @(negedge clk); #1;
    if (expQ.size() == 0) serIn = rx[0];
    expQ.push_back(e);
    lenSel  = 3'(code);
    txData  = tx;
    txWrite = 1'b1;
    @(negedge clk); #1;
    txWrite = 1'b0;
  endtask

  task automatic waitIdle();
    while (expQ.size() != 0) @(negedge clk);
    repeat (8) @(negedge clk);
    #1;
  endtask

  task automatic readRx();
    @(negedge clk); #1;
    rxRead = 1'b1;
    @(negedge clk); #1;
    rxRead = 1'b0;
    @(negedge clk); #1;
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int f0;
    repeat (4) @(negedge clk);
    #1;
    // R1 reset state
    chk(serClk == 1'b1, "R1 reset serClk", int'(serClk), 1);
    chk(serOut == 1'b1, "R1 reset serOut", int'(serOut), 1);
    chk(!rxFull && !rxOverrun && !rxIrq, "R1 reset flags",
        int'({rxFull, rxOverrun, rxIrq}), 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    // R2 write while disabled is dropped
    f0 = fallCount;
    @(negedge clk); #1;
    txData = 9'h0F0; txWrite = 1'b1;
    @(negedge clk); #1;
    txWrite = 1'b0;
    repeat (60) @(negedge clk);
    txEnable = 1'b1;
    repeat (60) @(negedge clk);
    #1;
    chk(fallCount == f0, "R2 disabled write ignored", fallCount, f0);

    // R2 R5 R7 basic 8-bit frame
    rxIntEn = 1'b1;
    sendFrame(9'h0A5, 9'h03C, 3, 1'b0);
    waitIdle();
    chk(rxData == 9'h03C, "R5 received data", int'(rxData), 'h03C);
    chk(rxFull == 1'b1, "R5 full flag set", int'(rxFull), 1);
    chk(rxIrq == 1'b1, "R7 irq with enable", int'(rxIrq), 1);
    chk(serOut && serClk, "R12 idle levels", int'({serOut, serClk}), 3);
    readRx();
    chk(!rxFull && !rxIrq, "R6 read clears full", int'({rxFull, rxIrq}), 0);

    // R3 frame lengths
    foreach (lenCodes[i]) begin
      sendFrame(9'h1D3 ^ 9'(i * 37), 9'h16B ^ 9'(i * 91), lenCodes[i], 1'b0);
      waitIdle();
      chk(rxData == ((9'h16B ^ 9'(i * 91)) & maskOf(lenOf(lenCodes[i]))),
          "R3 length and upper bits zero", int'(rxData),
          int'((9'h16B ^ 9'(i * 91)) & maskOf(lenOf(lenCodes[i]))));
      readRx();
    end

    // R7 irq masked, R8 overrun
    rxIntEn = 1'b0;
    sendFrame(9'h055, 9'h0C3, 3, 1'b0);
    waitIdle();
    chk(rxFull && !rxIrq, "R7 irq masked", int'({rxFull, rxIrq}), 2);
    sendFrame(9'h0AA, 9'h05A, 3, 1'b0);
    waitIdle();
    chk(rxOverrun == 1'b1, "R8 overrun set", int'(rxOverrun), 1);
    chk(rxData == 9'h05A, "R8 data replaced", int'(rxData), 'h05A);
    readRx();
    chk(!rxFull && !rxOverrun, "R6 read clears overrun", int'({rxFull, rxOverrun}), 0);

    // R10 chained frames with each pause code
    for (int w = 0; w < 4; w++) begin
      waitSel = 2'(w);
      sendFrame(9'h0E1, 9'h01E, 3, 1'b0);
      repeat (12) @(negedge clk);
      sendFrame(9'h136, 9'h0C9, 4, 1'b1);
      waitIdle();
      chk(rxData == 9'h0C9, "R10 second chained frame data", int'(rxData), 'h0C9);
      readRx();
    end
    waitSel = 2'd0;

    // R11 forced high output
    forceHigh = 1'b1;
    sendFrame(9'h000, 9'h0B4, 3, 1'b0);
    waitIdle();
    chk(rxData == 9'h0B4, "R11 reception while forced", int'(rxData), 'h0B4);
    forceHigh = 1'b0;

    // R9 read coincides with completion (rxFull already 1)
    chk(rxFull == 1'b1, "R9 setup full", int'(rxFull), 1);
    sendFrame(9'h0F3, 9'h09D, 3, 1'b0);
    do begin
      @(negedge clk); #1;
    end while (!(bitNum == 7 && !serClk && sckTick));
    rxRead = 1'b1;
    @(negedge clk); #1;
    rxRead = 1'b0;
    chk(rxFull == 1'b1, "R9 full stays set", int'(rxFull), 1);
    chk(rxOverrun == 1'b0, "R9 no overrun", int'(rxOverrun), 0);
    chk(rxData == 9'h09D, "R9 new data kept", int'(rxData), 'h09D);
    waitIdle();

    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  int lenCodes[5] = '{0, 1, 2, 4, 7};

endmodule